// File: doc/BRIEF.md
# Rectangular Frame-Buffer Transfer Engine

This block copies pixel data between a 32-bit host data port and a frame buffer that holds 16-bit pixels. The buffer is 2^X_BITS pixels wide and 2^Y_BITS rows tall; the defaults give 1024 by 512. A transfer is set up by one start pulse, which carries a position word, a size word and a direction. The engine then walks the rectangle row by row. Each pixel it reaches becomes one access on a synchronous single-port pixel memory. Each host word carries two pixels.

In the write direction the host offers words on a valid/ready handshake, and the engine writes both pixels of each word into the buffer. In the read direction the engine fetches two pixels, packs them into one word and presents it on a valid/ready output. The host may stall at any word boundary, including one that falls in the middle of a row, and the walk resumes at the next column. A busy output is high from the start pulse until the transfer completes. Arbitration for the pixel memory is handled outside the block.

Top module: `fb_rect_xfer`

## Requirements
- R1: The start column is position bits [X_BITS-1:0] and the start row is position bits [16+Y_BITS-1:16]. All other position bits are ignored. The pixel address is row*2^X_BITS + column, with the row in the upper address bits.
- R2: The width is ((size[15:0] - 1) mod 2^X_BITS) + 1, so a width field of zero selects the full buffer width.
- R3: The height is ((size[31:16] - 1) mod 2^Y_BITS) + 1, so a height field of zero selects the full buffer height.
- R4: Pixels are visited in row-major order. The column runs from the start column across the width, then returns to the start column on the next row.
- R5: When the rectangle runs past the buffer edge, the column wraps modulo 2^X_BITS and the row wraps modulo 2^Y_BITS.
- R6: In a write, bits [15:0] of a host word go to the earlier pixel position and bits [31:16] go to the next one. If the rectangle holds an odd number of pixels, the upper half of the final word is never written.
- R7: In a read, bits [15:0] of each output word hold the earlier pixel and bits [31:16] hold the next one. If the final word has only one pixel, its upper half is zero. While rd_valid is high and rd_ready is low, rd_data holds steady.
- R8: busy is low after reset and goes high in the cycle after a start. In a write it drops after the last pixel has been written. In a read it drops after the last word has been accepted.
- R9: The host may pause between any two words, including in the middle of a row. No memory access happens while the engine waits on the host, and the walk continues at the next column.
- R10: A start while a transfer is active abandons that transfer and begins the new one with the new position, size and direction.
- R11: While idle, or while reading, wr_ready is low and words offered on wr_data are ignored: no pixel is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request that begins a transfer |
| start_read | input | 1 | Direction at start: 1 moves buffer to host, 0 moves host to buffer |
| pos_word | input | 32 | Start column and start row |
| size_word | input | 32 | Width and height fields, minus-one encoded |
| wr_valid | input | 1 | Host offers a word to write |
| wr_data | input | 32 | Two pixels to write, earlier pixel in bits 15:0 |
| wr_ready | output | 1 | Engine accepts the offered word |
| rd_valid | output | 1 | A packed read word is available |
| rd_data | output | 32 | Two pixels read, earlier pixel in bits 15:0 |
| rd_ready | input | 1 | Host takes the read word |
| mem_en | output | 1 | Pixel memory access in this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | X_BITS+Y_BITS | Pixel address, row in the upper bits |
| mem_wdata | output | 16 | Pixel to write |
| mem_rdata | input | 16 | Pixel read, valid one cycle after the read access |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench builds the engine with X_BITS=4 and Y_BITS=3, which gives a 16 by 8 buffer. With these values a zero size field covers only 128 pixels, so the full-width and full-height encodings can be run completely. The buffer edges are also only a few pixels from any start point, so column and row wrap-around can be reached from both ends. Small rectangles with odd pixel counts, garbage bits above the position and size fields, host stalls in the middle of a row and a restart in the middle of a transfer are each run against a pixel-level scoreboard.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

    // Control states of the transfer engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_TAKE,  // waiting for a host word
        ST_WR_LO,    // writing the lower pixel of the held word
        ST_WR_HI,    // writing the upper pixel of the held word
        ST_RD_LO,    // issuing the read of the first pixel of a pair
        ST_RD_HI,    // capturing the first pixel, issuing the second
        ST_RD_CAP,   // capturing the second pixel
        ST_RD_OUT    // presenting the packed word to the host
    } xfer_state_e;

endpackage

// File: rtl/fbx_cursor.sv
module fbx_cursor #(
    parameter int X_BITS = 10,
    parameter int Y_BITS = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic [31:0]              pos_word,
    input  logic [31:0]              size_word,
    output logic [X_BITS+Y_BITS-1:0] pix_addr,
    output logic                     at_last
);

    localparam int AW = X_BITS + Y_BITS;

    typedef struct packed {
        logic [X_BITS-1:0] x0;
        logic [X_BITS-1:0] wm1;
        logic [X_BITS-1:0] col;
        logic [Y_BITS-1:0] y0;
        logic [Y_BITS-1:0] hm1;
        logic [Y_BITS-1:0] row;
    } cur_t;

    cur_t q, d;

    logic [15:0]       w_field_m1;
    logic [15:0]       h_field_m1;
    logic [X_BITS-1:0] x_now;
    logic [Y_BITS-1:0] y_now;
    logic              row_end;
    logic              unused_bits;

    assign unused_bits = ^{pos_word, size_word, w_field_m1, h_field_m1};

    always_comb begin
        w_field_m1 = size_word[15:0] - 16'd1;
        h_field_m1 = size_word[31:16] - 16'd1;
        row_end    = (q.col == q.wm1);
        d          = q;
        if (load) begin
            d.x0  = pos_word[X_BITS-1:0];
            d.y0  = pos_word[16 +: Y_BITS];
            d.wm1 = w_field_m1[X_BITS-1:0];
            d.hm1 = h_field_m1[Y_BITS-1:0];
            d.col = '0;
            d.row = '0;
        end else if (step) begin
            if (row_end) begin
                d.col = '0;
                d.row = q.row + 1'b1;
            end else begin
                d.col = q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Modular adds give wrap at the buffer edges
    assign x_now    = q.x0 + q.col;
    assign y_now    = q.y0 + q.row;
    assign pix_addr = AW'({y_now, x_now});
    assign at_last  = row_end && (q.row == q.hm1);

    // Column offset never passes the last column of the rectangle
    assert_col_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.col <= q.wm1);

    // Every step short of the end reaches a new pixel
    assert_addr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !at_last) |=> (pix_addr != $past(pix_addr)));

endmodule

// File: rtl/fbx_lane.sv
module fbx_lane #(
    parameter int PIX_W = 16
) (
    input  logic [2*PIX_W-1:0] word,
    input  logic               hi_sel,
    output logic [PIX_W-1:0]   pix
);

    always_comb begin
        pix = hi_sel ? word[2*PIX_W-1:PIX_W] : word[PIX_W-1:0];
    end

endmodule

// File: rtl/fb_rect_xfer.sv
module fb_rect_xfer #(
    parameter int X_BITS = 10,
    parameter int Y_BITS = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     start_read,
    input  logic [31:0]              pos_word,
    input  logic [31:0]              size_word,
    input  logic                     wr_valid,
    input  logic [31:0]              wr_data,
    output logic                     wr_ready,
    output logic                     rd_valid,
    output logic [31:0]              rd_data,
    input  logic                     rd_ready,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [X_BITS+Y_BITS-1:0] mem_addr,
    output logic [15:0]              mem_wdata,
    input  logic [15:0]              mem_rdata,
    output logic                     busy
);
    import fbx_pkg::*;

    localparam int PIX_W  = 16;
    localparam int WORD_W = 2 * PIX_W;
    localparam int AW     = X_BITS + Y_BITS;

    typedef struct packed {
        xfer_state_e        st;
        logic [WORD_W-1:0]  word;
        logic               fin;   // last pixel of the rectangle already issued
    } ctl_t;

    ctl_t q, d;

    logic          step;
    logic          hi_sel;
    logic          at_last;
    logic [AW-1:0] cur_addr;

    fbx_cursor #(
        .X_BITS (X_BITS),
        .Y_BITS (Y_BITS)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .step      (step),
        .pos_word  (pos_word),
        .size_word (size_word),
        .pix_addr  (cur_addr),
        .at_last   (at_last)
    );

    fbx_lane #(
        .PIX_W (PIX_W)
    ) u_lane (
        .word   (q.word),
        .hi_sel (hi_sel),
        .pix    (mem_wdata)
    );

    always_comb begin
        d      = q;
        step   = 1'b0;
        hi_sel = 1'b0;
        mem_en = 1'b0;
        mem_we = 1'b0;
        unique case (q.st)
            ST_WR_TAKE: begin
                if (wr_valid) begin
                    d.word = wr_data;
                    d.st   = ST_WR_LO;
                end
            end
            ST_WR_LO: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                step   = 1'b1;
                d.st   = at_last ? ST_IDLE : ST_WR_HI;
            end
            ST_WR_HI: begin
                hi_sel = 1'b1;
                mem_en = 1'b1;
                mem_we = 1'b1;
                step   = 1'b1;
                d.st   = at_last ? ST_IDLE : ST_WR_TAKE;
            end
            ST_RD_LO: begin
                mem_en = 1'b1;
                step   = 1'b1;
                d.fin  = at_last;
                d.st   = ST_RD_HI;
            end
            ST_RD_HI: begin
                d.word[PIX_W-1:0] = mem_rdata;
                if (q.fin) begin
                    d.word[WORD_W-1:PIX_W] = '0;
                    d.st                   = ST_RD_OUT;
                end else begin
                    mem_en = 1'b1;
                    step   = 1'b1;
                    d.fin  = at_last;
                    d.st   = ST_RD_CAP;
                end
            end
            ST_RD_CAP: begin
                d.word[WORD_W-1:PIX_W] = mem_rdata;
                d.st                   = ST_RD_OUT;
            end
            ST_RD_OUT: begin
                if (rd_ready) d.st = q.fin ? ST_IDLE : ST_RD_LO;
            end
            default: ;
        endcase
        // A new request always wins, abandoning any transfer in flight
        if (start) begin
            d.st  = start_read ? ST_RD_LO : ST_WR_TAKE;
            d.fin = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.word <= '0;
            q.fin  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr = cur_addr;
    assign wr_ready = (q.st == ST_WR_TAKE);
    assign rd_valid = (q.st == ST_RD_OUT);
    assign rd_data  = q.word;
    assign busy     = (q.st != ST_IDLE);

    assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_quiet_while_waiting_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready || rd_valid) |-> !mem_en);

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !start) |=> (rd_valid && $stable(rd_data)));

    assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_en && !wr_ready && !rd_valid));

endmodule

// File: tb/fb_rect_xfer_bench.sv
`timescale 1ns/1ps
module fb_rect_xfer_bench;

    localparam int XB = 4;
    localparam int YB = 3;
    localparam int AW = XB + YB;
    localparam int NX = 1 << XB;
    localparam int NY = 1 << YB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          start_read = 1'b0;
    logic [31:0]   pos_word = '0;
    logic [31:0]   size_word = '0;
    logic          wr_valid = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          wr_ready;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          rd_ready = 1'b0;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic          busy;

    always #2 clk = ~clk;   // 250 MHz

    fb_rect_xfer #(
        .X_BITS (XB),
        .Y_BITS (YB)
    ) u_fb_rect_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_read (start_read),
        .pos_word   (pos_word),
        .size_word  (size_word),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_ready   (rd_ready),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .busy       (busy)
    );

    int checks = 0;
    int fails  = 0;
    int rd_seed = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [AW-1:0] wq_a[$];
    logic [15:0]   wq_d[$];
    string         wq_t[$];
    logic [31:0]   rq_w[$];
    string         rq_t[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_pat(input logic [AW-1:0] a, input int seed);
        return 16'(int'(a) * 16'h0123 ^ seed * 16'h1F1F ^ 16'h5A00);
    endfunction

    function automatic logic [15:0] wpix(input int seed, input int i);
        return 16'(seed * 16'h0F31 + i * 16'h0103 + 16'h0800);
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int x0, input int y0, input int w, input int i);
        int c = i % w;
        int r = i / w;
        return AW'((((y0 + r) % NY) * NX) + ((x0 + c) % NX));
    endfunction

    // Synchronous pixel memory model: reads return a pattern of the address
    always @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= rd_pat(mem_addr, rd_seed);
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_en && mem_we) begin
                if (wq_a.size() == 0) begin
                    check(1'b0, "R11", "unexpected pixel write", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    logic [AW-1:0] ea;
                    logic [15:0]   ed;
                    string         et;
                    ea = wq_a.pop_front();
                    ed = wq_d.pop_front();
                    et = wq_t.pop_front();
                    check(mem_addr == ea && mem_wdata == ed, et, "pixel write {addr,data}",
                          {9'd0, mem_addr, mem_wdata}, {9'd0, ea, ed});
                end
            end
            if (rd_valid && rd_ready) begin
                if (rq_w.size() == 0) begin
                    check(1'b0, "R7", "unexpected read word", rd_data, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ew;
                    string       et2;
                    ew  = rq_w.pop_front();
                    et2 = rq_t.pop_front();
                    check(rd_data == ew, et2, "read word", rd_data, ew);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual busy=%0d expected transfer to finish", busy);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic start_xfer(input bit rd, input logic [31:0] pos, input logic [31:0] size);
        start      = 1'b1;
        start_read = rd;
        pos_word   = pos;
        size_word  = size;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R8", "busy after start", 32'(busy), 32'd1);
        @(posedge clk); #1;
    endtask

    task automatic send_word(input logic [31:0] data);
        wr_valid = 1'b1;
        wr_data  = data;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic wr_rect(input logic [31:0] pos, input logic [31:0] size, input int gap,
                           input int max_words, input int seed, input string tag);
        int x0, y0, w, h, n, nw, npush;
        bit partial;
        x0 = int'(pos[XB-1:0]);
        y0 = int'(pos[16 +: YB]);
        w  = ((int'(size[15:0]) - 1) & (NX - 1)) + 1;
        h  = ((int'(size[31:16]) - 1) & (NY - 1)) + 1;
        n  = w * h;
        nw = (n + 1) / 2;
        partial = (max_words > 0 && max_words < nw);
        if (partial) nw = max_words;
        npush = (2 * nw < n) ? 2 * nw : n;
        for (int i = 0; i < npush; i++) begin
            wq_a.push_back(exp_addr(x0, y0, w, i));
            wq_d.push_back(wpix(seed, i));
            wq_t.push_back(tag);
        end
        start_xfer(1'b0, pos, size);
        for (int k = 0; k < nw; k++) begin
            send_word({(2 * k + 1 < n) ? wpix(seed, 2 * k + 1) : 16'hDEAD, wpix(seed, 2 * k)});
            if (k < nw - 1 && gap > 0) begin
                repeat (gap) begin @(posedge clk); #1; end
                if (gap >= 2) begin
                    @(negedge clk);
                    check(mem_en == 1'b0, "R9", "memory quiet during host pause", 32'(mem_en), 32'd0);
                    @(posedge clk); #1;
                end
            end
        end
        if (!partial) begin
            @(negedge clk);
            check(busy == 1'b1, "R8", "busy while last pixels pending", 32'(busy), 32'd1);
            @(posedge clk); #1;
        end
        repeat (3) begin @(posedge clk); #1; end
        @(negedge clk);
        if (partial) begin
            check(busy == 1'b1, "R10", "busy while rectangle unfinished", 32'(busy), 32'd1);
        end else begin
            check(busy == 1'b0, "R8", "busy after last pixel", 32'(busy), 32'd0);
        end
        check(wq_a.size() == 0, tag, "pixels outstanding", 32'(wq_a.size()), 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic rd_rect(input logic [31:0] pos, input logic [31:0] size, input bit stall,
                           input int seed, input string tag);
        int x0, y0, w, h, n, nw, guard;
        logic [15:0] lo, hi;
        rd_seed = seed;
        x0 = int'(pos[XB-1:0]);
        y0 = int'(pos[16 +: YB]);
        w  = ((int'(size[15:0]) - 1) & (NX - 1)) + 1;
        h  = ((int'(size[31:16]) - 1) & (NY - 1)) + 1;
        n  = w * h;
        nw = (n + 1) / 2;
        for (int k = 0; k < nw; k++) begin
            lo = rd_pat(exp_addr(x0, y0, w, 2 * k), seed);
            hi = (2 * k + 1 < n) ? rd_pat(exp_addr(x0, y0, w, 2 * k + 1), seed) : 16'h0000;
            rq_w.push_back({hi, lo});
            rq_t.push_back(tag);
        end
        start_xfer(1'b1, pos, size);
        guard = 0;
        while (rq_w.size() > 0 && guard < 2000) begin
            @(posedge clk); #1;
            rd_ready = stall ? ~rd_ready : 1'b1;
            guard++;
        end
        rd_ready = 1'b0;
        check(rq_w.size() == 0, tag, "read words outstanding", 32'(rq_w.size()), 32'd0);
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy after last read word", 32'(busy), 32'd0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0 && wr_ready == 1'b0 && rd_valid == 1'b0 && mem_en == 1'b0,
              "R8", "reset state {busy,wr_ready,rd_valid,mem_en}",
              32'({busy, wr_ready, rd_valid, mem_en}), 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R6 R4: odd 3x3 rectangle, one-cycle host gaps
        wr_rect(32'h0001_0002, 32'h0003_0003, 1, 0, 1, "R6");
        // R1 R2 R3: garbage above every field -> x=3 y=5, 3 wide, 1 tall
        wr_rect(32'hABC5_7A63, 32'h0011_0023, 0, 0, 2, "R1");
        // R2 R3: zero fields select the whole buffer
        wr_rect(32'h0000_0000, 32'h0000_0000, 0, 0, 3, "R2");
        // R5 R9: wrap on both axes, long pauses mid-row
        wr_rect(32'h0007_000E, 32'h0002_0004, 3, 0, 4, "R5");
        // R10: abandon after two words, restart elsewhere
        wr_rect(32'h0002_0001, 32'h0002_0006, 0, 2, 5, "R10");
        wr_rect(32'h0005_0008, 32'h0002_0003, 0, 0, 6, "R10");
        // R7: read without stalls
        rd_rect(32'h0003_0004, 32'h0002_0005, 1'b0, 7, "R7");
        // R7 R9: odd read with host stalls
        rd_rect(32'h0000_0007, 32'h0001_0003, 1'b1, 8, "R7");
        // R5: read wrap with stalls
        rd_rect(32'h0006_000F, 32'h0003_0003, 1'b1, 9, "R5");

        // R11: idle engine ignores offered words
        wr_valid = 1'b1;
        wr_data  = 32'h1234_5678;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(wr_ready == 1'b0 && mem_en == 1'b0, "R11", "idle ignores host word",
                  32'({wr_ready, mem_en}), 32'd0);
            @(posedge clk); #1;
        end
        wr_valid = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11", "still idle after offered words", 32'(busy), 32'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule